// File: doc/BRIEF.md
# Register-Pair Swizzle Move Unit

This execution unit performs a four-lane swizzle move over an even-aligned register pair. The two 64-bit source operands, the register at the source number and the one after it, are split into four 32-bit lanes. A 12-bit immediate in the instruction then builds a new 128-bit pair from those lanes, from constants, or from nothing at all. The unit decodes the instruction word itself. It recognises an integer and a floating-point form. It rejects odd register numbers and any encoding it does not recognise.

A destination lane that the immediate skips has one of two outcomes. If the source pair and the destination pair are the same registers, the lane keeps its old value. If they are different registers, the lane is written as zero. All four source lanes are taken from the operand ports in a single cycle, so an in-place reordering that overlaps its own inputs, such as a full reversal, gives the correct result. A result appears one cycle after a valid request, together with a write enable for each of the two destination registers and an illegal flag.

Top module: `swz_move_unit`

## Requirements
- R1: The instruction word is read MSB-first: `instr[31:26]` is the primary opcode and must equal the parameter `PRIMARY_OP` (default 22), `instr[25:21]` is the destination number, `instr[20:16]` is the source number, `instr[15:4]` is the immediate and `instr[3:0]` is the extended opcode. An extended opcode of 4'b0011 selects the integer form (`out_fp`=0) and 4'b1011 selects the floating-point form (`out_fp`=1). Any other primary or extended opcode raises `out_illegal`.
- R2: The source lanes are numbered as follows: lane 0 is `src_lo[31:0]`, lane 1 is `src_lo[63:32]`, lane 2 is `src_hi[31:0]` and lane 3 is `src_hi[63:32]`. The destination lanes use the same positions in `out_lo` and `out_hi`.
- R3: Destination lane i is controlled by the 3-bit field `imm[11-3i -: 3]`. Codes 0 to 3 copy source lane 0 to 3 into it.
- R4: Code 4 writes zero into the lane and code 5 writes all ones.
- R5: Codes 6 and 7 skip the lane. When the source number equals the destination number, a skipped lane outputs its previous value, which is the source lane at the same position.
- R6: When the source and destination numbers differ, a skipped lane is written as zero.
- R7: An odd destination or source number raises `out_illegal`. While `out_illegal` is set, both write enables are low.
- R8: For a legal request with different source and destination numbers, both write enables are high. For a legal in-place request, a register's enable is high only if at least one of its two lanes is not skipped.
- R9: `out_valid` follows `in_valid` with exactly one cycle of latency. When `out_valid` is low, both write enables are low.
- R10: After a synchronous reset, `out_valid`, `out_illegal`, both write enables and the data outputs are zero.
- R11: An in-place swizzle whose result lanes overlap its source lanes uses only the original source values. For example, the code sequence 3,2,1,0 fully reverses the four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| instr | input | 32 | Instruction word |
| src_lo | input | 2*LANE_W | Even source register value |
| src_hi | input | 2*LANE_W | Odd (source+1) register value |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_illegal | output | 1 | Illegal-instruction flag |
| out_fp | output | 1 | Floating-point form decoded |
| out_we_lo | output | 1 | Write enable for the destination register |
| out_we_hi | output | 1 | Write enable for destination+1 |
| out_rt | output | 5 | Destination register number |
| out_lo | output | 2*LANE_W | Value for the destination register |
| out_hi | output | 2*LANE_W | Value for destination+1 |

## Verification
The hardest behaviour to reach from the ports is the split between keeping and zeroing skipped lanes. It needs a legal encoding, even register numbers that either match or differ, and skip codes mixed with copy codes. A uniform random immediate rarely produces a register with both lanes skipped in place. The stimulus therefore draws each 3-bit field with extra weight on the skip codes and picks the in-place case half the time. Directed cases add a full reversal, an all-skip in-place request and an all-skip separate request, and the odd-number, bad-opcode and idle-cycle cases.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int SEL_W = 3;
  localparam int NUM_LANES = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_L0   = 3'd0,
    SEL_L1   = 3'd1,
    SEL_L2   = 3'd2,
    SEL_L3   = 3'd3,
    SEL_ZERO = 3'd4,
    SEL_ONES = 3'd5,
    SEL_SKA  = 3'd6,
    SEL_SKB  = 3'd7
  } lane_sel_e;

  typedef struct packed {
    logic [5:0]  popc;
    logic [4:0]  rt;
    logic [4:0]  ra;
    logic [11:0] imm;
    logic [3:0]  xo;
  } swz_instr_t;

  localparam logic [3:0] XO_INT = 4'b0011;
  localparam logic [3:0] XO_FP  = 4'b1011;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic [31:0] instr,
  output logic [4:0]  rt,
  output logic [11:0] imm,
  output logic        is_fp,
  output logic        in_place,
  output logic        illegal
);
  swz_instr_t f;
  logic known_xo;

  assign f        = instr;
  assign rt       = f.rt;
  assign imm      = f.imm;
  assign is_fp    = (f.xo == XO_FP);
  assign known_xo = (f.xo == XO_INT) || (f.xo == XO_FP);
  assign in_place = (f.rt == f.ra);
  assign illegal  = (f.popc != PRIMARY_OP) || !known_xo || f.rt[0] || f.ra[0];
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [NUM_LANES*LANE_W-1:0] src,
  input  logic [NUM_LANES*SEL_W-1:0]  sel,
  input  logic                        in_place,
  output logic [NUM_LANES*LANE_W-1:0] dst,
  output logic [NUM_LANES-1:0]        lane_set
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_sel_e code;
    assign code = lane_sel_e'(sel[i*SEL_W +: SEL_W]);
    always_comb begin
      lane_set[i] = 1'b1;
      unique case (code)
        SEL_L0:   dst[i*LANE_W +: LANE_W] = src[0*LANE_W +: LANE_W];
        SEL_L1:   dst[i*LANE_W +: LANE_W] = src[1*LANE_W +: LANE_W];
        SEL_L2:   dst[i*LANE_W +: LANE_W] = src[2*LANE_W +: LANE_W];
        SEL_L3:   dst[i*LANE_W +: LANE_W] = src[3*LANE_W +: LANE_W];
        SEL_ZERO: dst[i*LANE_W +: LANE_W] = '0;
        SEL_ONES: dst[i*LANE_W +: LANE_W] = '1;
        default: begin
          lane_set[i] = 1'b0;
          dst[i*LANE_W +: LANE_W] = in_place ? src[i*LANE_W +: LANE_W] : '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
#(
  parameter int         LANE_W     = 32,
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [31:0]         instr,
  input  logic [2*LANE_W-1:0] src_lo,
  input  logic [2*LANE_W-1:0] src_hi,
  output logic                out_valid,
  output logic                out_illegal,
  output logic                out_fp,
  output logic                out_we_lo,
  output logic                out_we_hi,
  output logic [4:0]          out_rt,
  output logic [2*LANE_W-1:0] out_lo,
  output logic [2*LANE_W-1:0] out_hi
);
  localparam int REG_W = 2 * LANE_W;

  logic [4:0]                  dec_rt;
  logic [11:0]                 dec_imm;
  logic                        dec_fp, dec_inplace, dec_illegal;
  logic [NUM_LANES*SEL_W-1:0]  sel;
  logic [2*REG_W-1:0]          dst;
  logic [NUM_LANES-1:0]        lane_set;
  logic                        we_lo_n, we_hi_n;

  swz_decode #(.PRIMARY_OP(PRIMARY_OP)) u_dec (
    .instr    (instr),
    .rt       (dec_rt),
    .imm      (dec_imm),
    .is_fp    (dec_fp),
    .in_place (dec_inplace),
    .illegal  (dec_illegal)
  );

  // lane 0 control sits in the top field of the immediate
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_sel
    assign sel[i*SEL_W +: SEL_W] = dec_imm[(NUM_LANES-1-i)*SEL_W +: SEL_W];
  end

  swz_lane_mux #(.LANE_W(LANE_W)) u_mux (
    .src      ({src_hi, src_lo}),
    .sel      (sel),
    .in_place (dec_inplace),
    .dst      (dst),
    .lane_set (lane_set)
  );

  assign we_lo_n = in_valid && !dec_illegal && (!dec_inplace || (|lane_set[1:0]));
  assign we_hi_n = in_valid && !dec_illegal && (!dec_inplace || (|lane_set[3:2]));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_fp      <= 1'b0;
      out_we_lo   <= 1'b0;
      out_we_hi   <= 1'b0;
      out_rt      <= '0;
      out_lo      <= '0;
      out_hi      <= '0;
    end else begin
      out_valid <= in_valid;
      out_we_lo <= we_lo_n;
      out_we_hi <= we_hi_n;
      if (in_valid) begin
        out_illegal <= dec_illegal;
        out_fp      <= dec_fp;
        out_rt      <= dec_rt;
        out_lo      <= dst[REG_W-1:0];
        out_hi      <= dst[2*REG_W-1:REG_W];
      end
    end
  end
endmodule

// File: rtl/swz_move_chk.sv
module swz_move_chk
  import swz_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [31:0]         instr,
  input logic [2*LANE_W-1:0] src_lo,
  input logic                out_valid,
  input logic                out_illegal,
  input logic                out_we_lo,
  input logic                out_we_hi,
  input logic [2*LANE_W-1:0] out_lo
);
  swz_instr_t f;
  assign f = instr;

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_we_lo && !out_we_hi));

  // R7
  odd_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (f.rt[0] || f.ra[0])) |=> (out_illegal && !out_we_lo && !out_we_hi));

  // R5
  inplace_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (f.rt == f.ra) && (f.imm[11:10] == 2'b11))
      |=> (out_lo[LANE_W-1:0] == $past(src_lo[LANE_W-1:0])));
endmodule

bind swz_move_unit swz_move_chk #(.LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .src_lo      (src_lo),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_we_lo   (out_we_lo),
  .out_we_hi   (out_we_hi),
  .out_lo      (out_lo)
);

// File: tb/swz_move_unit_test.sv
module swz_move_unit_test;
  localparam int LW = 32;
  localparam logic [5:0] POP = 6'd22;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [31:0] instr = '0;
  logic [2*LW-1:0] src_lo = '0, src_hi = '0;
  logic out_valid, out_illegal, out_fp, out_we_lo, out_we_hi;
  logic [4:0] out_rt;
  logic [2*LW-1:0] out_lo, out_hi;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  swz_move_unit #(.LANE_W(LW), .PRIMARY_OP(POP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_lo(src_lo), .src_hi(src_hi), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_fp(out_fp), .out_we_lo(out_we_lo),
    .out_we_hi(out_we_hi), .out_rt(out_rt), .out_lo(out_lo), .out_hi(out_hi)
  );

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] rt,
      input logic [4:0] ra, input logic [11:0] imm, input logic [3:0] xo);
    return {p, rt, ra, imm, xo};
  endfunction

  function automatic void check(input string tag, input string what,
      input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  task automatic apply(input string tag, input logic [31:0] ins,
      input logic [63:0] a, input logic [63:0] b);
    logic [31:0] sl [4];
    logic [31:0] dl [4];
    logic [3:0] set;
    logic inpl, ill, fp, xo_ok, ewlo, ewhi;
    sl[0] = a[31:0]; sl[1] = a[63:32]; sl[2] = b[31:0]; sl[3] = b[63:32];
    inpl = ins[25:21] == ins[20:16];
    xo_ok = ins[3:0] == 4'b0011 || ins[3:0] == 4'b1011;
    ill = ins[31:26] != POP || !xo_ok || ins[21] || ins[16];
    fp = ins[3:0] == 4'b1011;
    for (int i = 0; i < 4; i++) begin
      logic [2:0] c;
      c = ins[15 - 3*i -: 3];
      set[i] = c < 3'd6;
      if (c < 3'd4) dl[i] = sl[c];
      else if (c == 3'd4) dl[i] = '0;
      else if (c == 3'd5) dl[i] = '1;
      else dl[i] = inpl ? sl[i] : '0;
    end
    ewlo = !ill && (!inpl || set[0] || set[1]);
    ewhi = !ill && (!inpl || set[2] || set[3]);
    @(negedge clk);
    instr = ins; src_lo = a; src_hi = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9", "valid", 128'(out_valid), 128'(1));
    check(ill ? "R7" : "R1", "illegal", 128'(out_illegal), 128'(ill));
    check("R8", "we_lo", 128'(out_we_lo), 128'(ewlo));
    check("R8", "we_hi", 128'(out_we_hi), 128'(ewhi));
    if (!ill) begin
      check("R1", "fp", 128'(out_fp), 128'(fp));
      check("R1", "rt", 128'(out_rt), 128'(ins[25:21]));
      check(tag, "data", {out_hi, out_lo}, {dl[3], dl[2], dl[1], dl[0]});
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL R9 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [63:0] A = 64'h1111_1111_0000_0000;
  localparam logic [63:0] B = 64'h3333_3333_2222_2222;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset", {out_valid, out_illegal, out_we_lo, out_we_hi, out_lo, out_hi},
          '0);
    rst = 0;
    // R2 R3 identity copy to another pair
    apply("R2", mk(POP, 5'd4, 5'd2, 12'b000_001_010_011, 4'b0011), A, B);
    // R11 full reversal in place
    apply("R11", mk(POP, 5'd6, 5'd6, 12'b011_010_001_000, 4'b0011), A, B);
    // R4 zero and ones
    apply("R4", mk(POP, 5'd0, 5'd2, 12'b100_101_100_101, 4'b1011), A, B);
    // R5 all skip in place: both enables low, data kept
    apply("R5", mk(POP, 5'd8, 5'd8, 12'b110_111_110_111, 4'b0011), A, B);
    // R5 upper register skipped in place
    apply("R5", mk(POP, 5'd8, 5'd8, 12'b001_000_110_111, 4'b0011), A, B);
    // R6 all skip separate pair
    apply("R6", mk(POP, 5'd10, 5'd8, 12'b110_111_110_111, 4'b0011), A, B);
    // R7 odd numbers
    apply("R7", mk(POP, 5'd5, 5'd2, 12'b0, 4'b0011), A, B);
    apply("R7", mk(POP, 5'd4, 5'd3, 12'b0, 4'b0011), A, B);
    // R1 bad extended and primary opcode
    apply("R1", mk(POP, 5'd4, 5'd2, 12'b0, 4'b0111), A, B);
    apply("R1", mk(6'd31, 5'd4, 5'd2, 12'b0, 4'b0011), A, B);
    // R9 idle cycle after a request
    @(negedge clk);
    check("R9", "idle valid", 128'(out_valid), 128'(0));
    check("R9", "idle we", 128'({out_we_lo, out_we_hi}), 128'(0));
    for (int n = 0; n < 400; n++) begin
      logic [11:0] imm;
      logic [4:0] ra, rt;
      for (int k = 0; k < 4; k++)
        imm[11 - 3*k -: 3] = ($urandom_range(0, 2) == 0) ? 3'(6 + $urandom_range(0, 1))
                                                         : 3'($urandom_range(0, 5));
      ra = 5'($urandom_range(0, 15) * 2);
      rt = ($urandom_range(0, 1) != 0) ? ra : 5'($urandom_range(0, 15) * 2);
      if ($urandom_range(0, 19) == 0) rt[0] = 1'b1;
      apply("R3", mk(POP, rt, ra, imm, ($urandom_range(0, 1) != 0) ? 4'b0011 : 4'b1011),
            {$urandom, $urandom}, {$urandom, $urandom});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule